// File: doc/BRIEF.md
# Cache Tag Store with Equality Match

This block is a tag memory for a cache controller: 4096 entries of 4 bits each, with an equality comparator on the addressed entry and a clear that empties the whole array in one operation. On every clock edge the block decodes one operation from three active-low controls. It can compare the data-in bus against the stored entry, read the entry out, write the data-in bus into the entry, or clear the array.

All storage updates happen on the rising clock edge. Read data, the data-out enable and the match flag are registered, so each appears one cycle after the address, data and controls that produced it. The clear does not step through the array. Each entry has a valid bit, and a clear drops every valid bit at once. An entry whose valid bit is down reads as zero. Writing an entry raises its valid bit.

The operation is chosen by priority. A clear beats a write, and a write beats a read. The match flag follows the comparator in every mode except clear: a lookup gives a real result, while reads and writes always report a match. A cache controller applies a set index and an incoming tag and samples the match flag on the next cycle to decide hit or miss.

Top module: `tag_match_ram`

## Requirements
- R1: When clr_n, we_n and oe_n are all high at a rising edge (lookup), match one cycle later is 1 if all 4 bits of din equal the addressed entry. An entry holds the value last written to it since the last clear or reset, or 0 if it has not been written since then.
- R2: In a lookup, a difference in any single bit between din and the addressed entry makes match 0 one cycle later.
- R3: When we_n is low and clr_n is high at a rising edge, din is stored at addr. The level of oe_n has no effect on this write.
- R4: In the cycle after a write, match is 1 and dout_en is 0.
- R5: When clr_n and we_n are high and oe_n is low at a rising edge (read), one cycle later dout equals the addressed entry, dout_en is 1 and match is 1.
- R6: When clr_n is low at a rising edge, every entry becomes 0. This shows in reads and lookups that follow.
- R7: If clr_n and we_n are both low at the same edge, the write is discarded and the addressed entry reads 0 afterwards.
- R8: In the cycle after a lookup, dout_en is 0.
- R9: While rst_n is low, dout_en and match are 0 and every entry reads as 0 after reset is released.
- R10: Results have exactly one cycle of latency. A read issued on the edge right after a write to the same address returns the newly written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 12 | Entry address |
| din | input | 4 | Write data and lookup tag |
| oe_n | input | 1 | Active-low read request |
| we_n | input | 1 | Active-low write request |
| clr_n | input | 1 | Active-low whole-array clear |
| dout | output | 4 | Registered read data, meaningful when dout_en is 1 |
| dout_en | output | 1 | Registered data-out enable |
| match | output | 1 | Registered comparator result |

## Verification
The assertions assume that the controls, addr and din hold known values at every rising edge after reset. They also place no demand on dout or match in the cycle after a clear, because those values are undefined there. The bench changes every input only at the falling edge and never checks outputs after a clear. Random traffic is kept to a narrow address window and uses a small clear rate, so that addresses are often rewritten, lookups that hit are common, and clears that land alongside a write do occur.

// File: rtl/tagram_pkg.sv
package tagram_pkg;

  typedef enum logic [1:0] {
    OP_LOOKUP = 2'd0,
    OP_READ   = 2'd1,
    OP_WRITE  = 2'd2,
    OP_WIPE   = 2'd3
  } tag_op_e;

endpackage

// File: rtl/tagram_decode.sv
module tagram_decode
  import tagram_pkg::*;
(
  input  logic    oe_n,
  input  logic    we_n,
  input  logic    clr_n,
  output tag_op_e op
);

  // Priority: wipe over write over read; all idle means lookup.
  always_comb begin
    if (!clr_n) begin
      op = OP_WIPE;
    end else if (!we_n) begin
      op = OP_WRITE;
    end else if (!oe_n) begin
      op = OP_READ;
    end else begin
      op = OP_LOOKUP;
    end
  end

endmodule

// File: rtl/tagram_store.sv
module tagram_store
  import tagram_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tag_op_e           op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  valid_q;
  logic [DEPTH-1:0]  valid_d;
  logic              wr_en;
  logic              wipe;

  assign wr_en = (op == OP_WRITE);
  assign wipe  = (op == OP_WIPE);

  // Valid-bit next state: a wipe drops every bit, a write raises one.
  always_comb begin
    valid_d = valid_q;
    if (wipe) begin
      valid_d = '0;
    end else if (wr_en) begin
      valid_d[addr] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else begin
      valid_q <= valid_d;
    end
  end

  // Data array: no reset, write enable only.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[addr] <= wdata;
    end
  end

  assign rdata = valid_q[addr] ? mem[addr] : '0;

endmodule

// File: rtl/tagram_outreg.sv
module tagram_outreg
  import tagram_pkg::*;
#(
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tag_op_e           op,
  input  logic              oe_n,
  input  logic [DATA_W-1:0] din,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic              match
);

  logic [DATA_W-1:0] cmp_a;
  logic [DATA_W-1:0] cmp_b;
  logic [DATA_W-1:0] bit_eq;
  logic              match_d;
  logic              en_d;
  logic              dout_ce;

  // The comparator sees whatever is on the data bus against the entry.
  // During a read the bus carries the entry; during a write it carries din.
  always_comb begin
    cmp_a = (op == OP_READ)  ? rdata : din;
    cmp_b = (op == OP_WRITE) ? din   : rdata;
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_eq
    assign bit_eq[i] = ~(cmp_a[i] ^ cmp_b[i]);
  end

  always_comb begin
    match_d = (op == OP_WIPE) ? 1'b0 : &bit_eq;
    en_d    = (op == OP_READ) || ((op == OP_WIPE) && !oe_n);
    dout_ce = (op == OP_READ) || (op == OP_WIPE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match   <= 1'b0;
      dout_en <= 1'b0;
    end else begin
      match   <= match_d;
      dout_en <= en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout <= '0;
    end else if (dout_ce) begin
      dout <= rdata;
    end
  end

endmodule

// File: rtl/tag_match_ram.sv
module tag_match_ram
  import tagram_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              clr_n,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic              match
);

  tag_op_e           op;
  logic [DATA_W-1:0] rdata;

  tagram_decode u_dec (
    .oe_n  (oe_n),
    .we_n  (we_n),
    .clr_n (clr_n),
    .op    (op)
  );

  tagram_store #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .op    (op),
    .addr  (addr),
    .wdata (din),
    .rdata (rdata)
  );

  tagram_outreg #(
    .DATA_W (DATA_W)
  ) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .op      (op),
    .oe_n    (oe_n),
    .din     (din),
    .rdata   (rdata),
    .dout    (dout),
    .dout_en (dout_en),
    .match   (match)
  );

endmodule

// File: rtl/tag_match_ram_chk.sv
module tag_match_ram_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] din,
  input logic              oe_n,
  input logic              we_n,
  input logic              clr_n,
  input logic [DATA_W-1:0] dout,
  input logic              dout_en,
  input logic              match
);

  assert_write_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && !we_n) |=> (match && !dout_en));

  assert_read_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && we_n && !oe_n) |=> (match && dout_en));

  assert_lookup_noen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && we_n && oe_n) |=> !dout_en);

  // R6 / R7: a read right after a wipe (with or without a write beside it) sees zero.
  assert_read_after_wipe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(clr_n) && clr_n && we_n && !oe_n) |=> (dout == '0));

  assert_lookup_after_wipe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(clr_n) && clr_n && we_n && oe_n) |=> (match == ($past(din) == '0)));

  // R10: back-to-back write then read at one address returns the written value.
  assert_write_then_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(clr_n) && !$past(we_n) && clr_n && we_n && !oe_n && (addr == $past(addr)))
      |=> (dout == $past(din, 2)));

endmodule

bind tag_match_ram tag_match_ram_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .addr    (addr),
  .din     (din),
  .oe_n    (oe_n),
  .we_n    (we_n),
  .clr_n   (clr_n),
  .dout    (dout),
  .dout_en (dout_en),
  .match   (match)
);

// File: tb/tb_tag_match_ram.sv
`timescale 1ns/1ps
module tb_tag_match_ram;

  localparam int AW    = 12;
  localparam int DW    = 4;
  localparam int DEPTH = 1 << AW;

  localparam int K_LOOK = 0;
  localparam int K_READ = 1;
  localparam int K_WR   = 2;
  localparam int K_WIPE = 3;

  logic          clk;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] din;
  logic          oe_n, we_n, clr_n;
  logic [DW-1:0] dout;
  logic          dout_en, match;

  logic [DW-1:0] model [DEPTH];
  int checks;
  int errors;
  bit done;

  tag_match_ram #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din),
    .oe_n(oe_n), .we_n(we_n), .clr_n(clr_n),
    .dout(dout), .dout_en(dout_en), .match(match)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit exp_match(input int kind, input logic [DW-1:0] d, input logic [DW-1:0] e);
    if (kind == K_LOOK) return (d == e);
    return 1'b1;
  endfunction

  function automatic bit exp_en(input int kind);
    return (kind == K_READ);
  endfunction

  task automatic wipe_model();
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
  endtask

  // Drive at a falling edge, let one rising edge pass, check at the next falling edge.
  // oe_x is the oe_n level used for writes and wipes.
  task automatic do_op(input int kind, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input logic oe_x, input logic we_x, input string req);
    logic [DW-1:0] e;
    e     = model[a];
    addr  = a;
    din   = d;
    clr_n = (kind != K_WIPE);
    we_n  = (kind == K_WIPE) ? we_x : (kind != K_WR);
    oe_n  = (kind == K_READ) ? 1'b0 : ((kind == K_LOOK) ? 1'b1 : oe_x);
    @(posedge clk);
    if (kind == K_WR) model[a] = d;
    if (kind == K_WIPE) wipe_model();
    @(negedge clk);
    if (kind != K_WIPE) begin
      chk(match == exp_match(kind, d, e), req, match, exp_match(kind, d, e));
      chk(dout_en == exp_en(kind), req, dout_en, exp_en(kind));
      if (kind == K_READ) chk(dout == e, req, dout, e);
    end
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    int unused_seed;
    checks = 0;
    errors = 0;
    done   = 1'b0;
    unused_seed = $urandom(32'h5eed_1234);
    wipe_model();
    rst_n = 1'b0;
    addr = '0; din = '0; oe_n = 1'b1; we_n = 1'b1; clr_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!dout_en, "R9 dout_en in reset", dout_en, 0);
    chk(!match, "R9 match in reset", match, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: untouched entries read zero after reset
    do_op(K_READ, 12'h000, 4'h0, 1'b1, 1'b1, "R9 read after reset");
    do_op(K_READ, 12'hFFF, 4'h0, 1'b1, 1'b1, "R9 read top after reset");
    do_op(K_LOOK, 12'h123, 4'h0, 1'b1, 1'b1, "R1 zero lookup after reset");

    // R3/R4 writes, one with oe_n low
    do_op(K_WR, 12'h010, 4'hA, 1'b1, 1'b0, "R4 write oe high");
    do_op(K_WR, 12'h011, 4'h5, 1'b0, 1'b0, "R3 write oe low");
    do_op(K_READ, 12'h011, 4'h0, 1'b1, 1'b1, "R3 readback oe-low write");
    do_op(K_READ, 12'h010, 4'h0, 1'b1, 1'b1, "R5 readback");

    // R1/R2 lookups: hit and single-bit misses
    do_op(K_LOOK, 12'h010, 4'hA, 1'b1, 1'b1, "R1 lookup hit");
    for (int b = 0; b < DW; b++)
      do_op(K_LOOK, 12'h010, 4'hA ^ (4'h1 << b), 1'b1, 1'b1, $sformatf("R2 miss bit %0d", b));
    do_op(K_LOOK, 12'h011, 4'hA, 1'b1, 1'b1, "R2 all bits differ");

    // R10: write then read same address on consecutive edges
    do_op(K_WR, 12'h200, 4'h7, 1'b1, 1'b0, "R10 write");
    do_op(K_READ, 12'h200, 4'h0, 1'b1, 1'b1, "R10 read next edge");
    do_op(K_WR, 12'h200, 4'hC, 1'b1, 1'b0, "R10 overwrite");
    do_op(K_LOOK, 12'h200, 4'hC, 1'b1, 1'b1, "R10 lookup next edge");

    // R6/R7: wipe together with a write
    do_op(K_WIPE, 12'h300, 4'hF, 1'b0, 1'b0, "R7 wipe with write");
    do_op(K_READ, 12'h300, 4'h0, 1'b1, 1'b1, "R7 discarded write reads zero");
    do_op(K_READ, 12'h010, 4'h0, 1'b1, 1'b1, "R6 wiped entry reads zero");
    do_op(K_LOOK, 12'h200, 4'hC, 1'b1, 1'b1, "R6 old tag misses");
    do_op(K_LOOK, 12'h200, 4'h0, 1'b1, 1'b1, "R6 zero tag hits");

    // Random traffic in a narrow window
    for (int n = 0; n < 4000; n++) begin
      int r;
      int kind;
      r = $urandom_range(0, 199);
      if (r == 0) kind = K_WIPE;
      else if (r < 70) kind = K_WR;
      else if (r < 130) kind = K_READ;
      else kind = K_LOOK;
      a = AW'($urandom_range(0, 31));
      d = DW'($urandom_range(0, 15));
      if (kind == K_LOOK && $urandom_range(0, 1) == 1) d = model[a];
      case (kind)
        K_WR:    do_op(kind, a, d, 1'($urandom_range(0, 1)), 1'b0, "R3 random write");
        K_READ:  do_op(kind, a, d, 1'b1, 1'b1, "R5 random read");
        K_LOOK:  do_op(kind, a, d, 1'b1, 1'b1, "R1 random lookup");
        default: do_op(kind, a, d, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), "R6 random wipe");
      endcase
    end

    // Final sweep of the window against the model
    for (int i = 0; i < 32; i++)
      do_op(K_READ, AW'(i), 4'h0, 1'b1, 1'b1, "R5 final sweep");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule